// File: doc/BRIEF.md
# Multi-Mode Microcontroller Serial Port

A full-duplex serial port of the kind found in small 8-bit controllers, driven through a two-address register bus. Address 0 is a shared data address: a write hands a byte to the transmitter, and a read returns a separate receive buffer. Address 1 is a control and status register. It holds the mode, the receive enable, the transmitted and received ninth bits, the transmit-done and receive-done flags, and the rate-double bit.

Three modes are supported. In the synchronous shift mode, data moves on the bidirectional data line and the transmit pin carries the shift clock. The 10-bit asynchronous mode uses an external 16x baud tick. The 11-bit asynchronous mode has a programmable ninth bit and derives its own 16x tick from the system clock. Asynchronous receivers find the start bit, take a three-sample vote at mid-bit and hold a finished byte in a separate buffer. This lets a second frame arrive before software reads the first.

Top module: `mcu_serial_port`

## Requirements
- R1: After reset the control register reads 0x00, the data register reads 0x00, txd_o is 1 and rxd_oe_o is 0.
- R2: Writing the data address starts a transmission and does not alter the value read back from the data address, which is the receive buffer.
- R3: Mode 1 (control bits [1:0] = 1) sends start 0, eight data bits LSB first and stop 1. Each bit lasts 16 baud_tick_i pulses. TI (control bit 5) is still 0 at mid-stop and is 1 after the stop bit ends.
- R4: Mode 2 (control bits [1:0] = 2) sends start 0, eight data bits LSB first, TB8 (control bit 3) and stop 1. A bit lasts 64 clocks when SMOD (control bit 7) is 0 and 32 clocks when it is 1.
- R5: In mode 1 with REN (control bit 2) set, a received byte is placed in the receive buffer, the stop bit goes to RB8 (control bit 4) and RI (control bit 6) is set.
- R6: In mode 2 reception, the ninth bit goes to RB8 and the stop bit level is ignored.
- R7: Each asynchronous bit is decided by a majority vote of three consecutive 16x samples at mid-bit, so a one-sample glitch does not change the bit.
- R8: A low pulse on rxd_i that is back to 1 at mid-start-bit is rejected: no byte is loaded and RI stays 0.
- R9: With REN at 0, asynchronous frames are not received: RI stays 0 and the buffer is unchanged.
- R10: If a frame completes while RI is still 1, that frame is dropped and the buffer keeps the earlier byte. A frame that started before the buffer was read and RI was cleared is received normally.
- R11: Mode 0 (control bits [1:0] = 0) transmit drives data LSB first on rxd_o with rxd_oe_o at 1. Each bit lasts 12 clocks. txd_o is low for the first 6 clocks of the bit and high for the last 6. TI is set after the eighth bit.
- R12: Mode 0 reception runs only while RI is 0 and REN is 1. It produces the same 12-clock shift clock on txd_o, samples rxd_i on each rising edge, and sets RI after eight bits.
- R13: TI and RI are never cleared by hardware. They stay set across reads and idle time until a control write clears them.
- R14: In the asynchronous modes, transmit and receive run at the same time without disturbing each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 1 | 0 selects data, 1 selects control |
| bus_we_i | input | 1 | Write strobe, one clock per write |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the selected address (combinational) |
| baud_tick_i | input | 1 | 16x bit-rate tick for mode 1 |
| rxd_i | input | 1 | Serial receive line |
| rxd_o | output | 1 | Mode 0 transmit data |
| rxd_oe_o | output | 1 | Drive enable for rxd_o |
| txd_o | output | 1 | Async transmit line, or the mode 0 shift clock |

## Verification
The hardest case to reach is a frame that overlaps the buffer being full. It shows whether the receive buffer holds an unread byte while the next frame is already being shifted in. The stimulus covers both orders. In one, a second frame lands on top of an unread byte. In the other, a frame is launched and, halfway through, a concurrent branch reads the buffer and clears RI. The glitch case needs a low pulse exactly as wide as one 16x tick period, centred on a data bit's middle, so that it can corrupt exactly one of the three votes.

// File: rtl/serial_pkg.sv
package serial_pkg;
  typedef enum logic [1:0] {
    SP_SHIFT   = 2'd0,
    SP_ASYNC10 = 2'd1,
    SP_ASYNC11 = 2'd2,
    SP_ASYNC11_ALT = 2'd3
  } sp_mode_e;

  typedef struct packed {
    logic     smod;
    logic     ri;
    logic     ti;
    logic     rb8;
    logic     tb8;
    logic     ren;
    sp_mode_e mode;
  } sp_ctrl_t;

  localparam logic ADDR_DATA = 1'b0;
  localparam logic ADDR_CTRL = 1'b1;
endpackage

// File: rtl/serial_rate_gen.sv
module serial_rate_gen
  import serial_pkg::*;
#(
  parameter int OVS      = 16,
  parameter int SLOW_BIT = 64,
  parameter int FAST_BIT = 32
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  sp_mode_e mode_i,
  input  logic     smod_i,
  input  logic     baud_tick_i,
  output logic     tick_o
);
  localparam int SLOW_DIV = SLOW_BIT / OVS;
  localparam int FAST_DIV = FAST_BIT / OVS;
  localparam int CW = $clog2(SLOW_DIV + 1);

  logic [CW-1:0] cnt_q, lim;
  logic m2_tick;

  assign lim     = smod_i ? CW'(FAST_DIV - 1) : CW'(SLOW_DIV - 1);
  assign m2_tick = (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (m2_tick) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    unique case (mode_i)
      SP_SHIFT:   tick_o = 1'b0;
      SP_ASYNC10: tick_o = baud_tick_i;
      default:    tick_o = m2_tick;
    endcase
  end
endmodule

// File: rtl/serial_tx.sv
module serial_tx #(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          start_i,
  input  logic          nine_i,
  input  logic [DW-1:0] data_i,
  input  logic          tb8_i,
  output logic          txd_o,
  output logic          done_o
);
  localparam int FW = DW + 3;
  localparam int SW = $clog2(OVS);
  localparam int IW = $clog2(FW);
  localparam logic [SW-1:0] SUB_END = SW'(OVS - 1);

  logic [FW-1:0] sh_q;
  logic [SW-1:0] sub_q;
  logic [IW-1:0] idx_q, last;
  logic busy_q, done_q, nine_q;

  assign last = nine_q ? IW'(FW - 1) : IW'(FW - 2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      sub_q  <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      nine_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        sh_q   <= {1'b1, (nine_i ? tb8_i : 1'b1), data_i, 1'b0};
        sub_q  <= '0;
        idx_q  <= '0;
        busy_q <= 1'b1;
        nine_q <= nine_i;
      end else if (busy_q && tick_i) begin
        if (sub_q == SUB_END) begin
          sub_q <= '0;
          if (idx_q == last) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            sh_q  <= {1'b1, sh_q[FW-1:1]};
            idx_q <= idx_q + 1'b1;
          end
        end else begin
          sub_q <= sub_q + 1'b1;
        end
      end
    end
  end

  assign txd_o  = busy_q ? sh_q[0] : 1'b1;
  assign done_o = done_q;

  // R3
  stop_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(txd_o));
endmodule

// File: rtl/serial_rx.sv
module serial_rx #(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          rxd_i,
  input  logic          ren_i,
  input  logic          nine_i,
  output logic [DW-1:0] data_o,
  output logic          bit9_o,
  output logic          done_o
);
  localparam int SW = $clog2(OVS);
  localparam int IW = $clog2(DW + 3);
  localparam logic [SW-1:0] S_A   = SW'(OVS / 2 - 2);
  localparam logic [SW-1:0] S_B   = SW'(OVS / 2 - 1);
  localparam logic [SW-1:0] S_C   = SW'(OVS / 2);
  localparam logic [SW-1:0] S_END = SW'(OVS - 1);
  localparam logic [IW-1:0] I_DLAST = IW'(DW);
  localparam logic [IW-1:0] I_NINE  = IW'(DW + 1);

  logic busy_q, done_q, nine_q, v0_q, v1_q, b9_q, maj;
  logic [SW-1:0] sub_q;
  logic [IW-1:0] idx_q;
  logic [DW-1:0] sh_q;

  // two stored votes plus the live sample
  assign maj = (v0_q & v1_q) | (v0_q & rxd_i) | (v1_q & rxd_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      nine_q <= 1'b0;
      v0_q   <= 1'b1;
      v1_q   <= 1'b1;
      b9_q   <= 1'b0;
      sub_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (tick_i && ren_i && !rxd_i) begin
          busy_q <= 1'b1;
          sub_q  <= '0;
          idx_q  <= '0;
          nine_q <= nine_i;
        end
      end else if (tick_i) begin
        if (sub_q == S_END) begin
          sub_q <= '0;
          idx_q <= idx_q + 1'b1;
        end else begin
          sub_q <= sub_q + 1'b1;
        end
        if (sub_q == S_A) v0_q <= rxd_i;
        if (sub_q == S_B) v1_q <= rxd_i;
        if (sub_q == S_C) begin
          if (idx_q == '0) begin
            if (maj) busy_q <= 1'b0;
          end else if (idx_q <= I_DLAST) begin
            sh_q <= {maj, sh_q[DW-1:1]};
          end else if (idx_q == I_NINE) begin
            b9_q <= maj;
            if (!nine_q) begin
              busy_q <= 1'b0;
              done_q <= 1'b1;
            end
          end else begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end
    end
  end

  assign data_o = sh_q;
  assign bit9_o = b9_q;
  assign done_o = done_q;

  // R9
  no_start_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(ren_i));
endmodule

// File: rtl/serial_sync.sv
module serial_sync #(
  parameter int DW  = 8,
  parameter int DIV = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tx_start_i,
  input  logic [DW-1:0] tx_data_i,
  input  logic          rx_req_i,
  input  logic          rxd_i,
  output logic          clk_o,
  output logic          dat_o,
  output logic          oe_o,
  output logic          busy_o,
  output logic          tx_done_o,
  output logic          rx_done_o,
  output logic [DW-1:0] rx_data_o
);
  localparam int PW = $clog2(DIV);
  localparam int CW = $clog2(DW);
  localparam logic [PW-1:0] HALF  = PW'(DIV / 2);
  localparam logic [PW-1:0] LAST  = PW'(DIV - 1);
  localparam logic [CW-1:0] CLAST = CW'(DW - 1);

  logic busy_q, is_tx_q, tx_done_q, rx_done_q;
  logic [PW-1:0] phase_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      is_tx_q   <= 1'b0;
      tx_done_q <= 1'b0;
      rx_done_q <= 1'b0;
      phase_q   <= '0;
      cnt_q     <= '0;
      sh_q      <= '0;
    end else begin
      tx_done_q <= 1'b0;
      rx_done_q <= 1'b0;
      if (tx_start_i) begin
        busy_q  <= 1'b1;
        is_tx_q <= 1'b1;
        sh_q    <= tx_data_i;
        phase_q <= '0;
        cnt_q   <= '0;
      end else if (!busy_q) begin
        // flag update lands one cycle after done; hold off re-arm meanwhile
        if (rx_req_i && !rx_done_q) begin
          busy_q  <= 1'b1;
          is_tx_q <= 1'b0;
          phase_q <= '0;
          cnt_q   <= '0;
        end
      end else begin
        if (phase_q == HALF && !is_tx_q) sh_q <= {rxd_i, sh_q[DW-1:1]};
        if (phase_q == LAST) begin
          phase_q <= '0;
          if (is_tx_q) sh_q <= {1'b1, sh_q[DW-1:1]};
          if (cnt_q == CLAST) begin
            busy_q <= 1'b0;
            if (is_tx_q) tx_done_q <= 1'b1;
            else rx_done_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end else begin
          phase_q <= phase_q + 1'b1;
        end
      end
    end
  end

  assign clk_o     = busy_q ? (phase_q >= HALF) : 1'b1;
  assign oe_o      = busy_q & is_tx_q;
  assign dat_o     = oe_o ? sh_q[0] : 1'b1;
  assign busy_o    = busy_q;
  assign tx_done_o = tx_done_q;
  assign rx_done_o = rx_done_q;
  assign rx_data_o = sh_q;

  // R11
  m0_tx_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_o |-> $past(oe_o));
endmodule

// File: rtl/mcu_serial_port.sv
module mcu_serial_port
  import serial_pkg::*;
#(
  parameter int OVS       = 16,
  parameter int SHIFT_DIV = 12,
  parameter int SLOW_BIT  = 64,
  parameter int FAST_BIT  = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bus_addr_i,
  input  logic       bus_we_i,
  input  logic [7:0] bus_wdata_i,
  output logic [7:0] bus_rdata_o,
  input  logic       baud_tick_i,
  input  logic       rxd_i,
  output logic       rxd_o,
  output logic       rxd_oe_o,
  output logic       txd_o
);
  localparam int DW = 8;

  sp_ctrl_t ctrl_q;
  logic [DW-1:0] rbuf_q;
  logic [1:0] rx_sync_q;
  logic rxd_s, wr_data, wr_ctrl, is_shift, nine, tick16;
  logic a_txd, a_tx_done, a_rx_done, a_bit9;
  logic [DW-1:0] a_rx_data, s_rx_data, rx_data_any;
  logic s_clk, s_dat, s_oe, s_busy, s_tx_done, s_rx_done, m0_rx_req;
  logic tx_done_any, rx_done_any, load_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rx_sync_q <= 2'b11;
    else rx_sync_q <= {rx_sync_q[0], rxd_i};
  end
  assign rxd_s = rx_sync_q[1];

  assign wr_data   = bus_we_i && (bus_addr_i == ADDR_DATA);
  assign wr_ctrl   = bus_we_i && (bus_addr_i == ADDR_CTRL);
  assign is_shift  = (ctrl_q.mode == SP_SHIFT);
  assign nine      = ctrl_q.mode[1];
  assign m0_rx_req = is_shift && ctrl_q.ren && !ctrl_q.ri && !wr_data;

  serial_rate_gen #(.OVS(OVS), .SLOW_BIT(SLOW_BIT), .FAST_BIT(FAST_BIT)) u_rate (
    .clk_i, .rst_ni, .mode_i(ctrl_q.mode), .smod_i(ctrl_q.smod),
    .baud_tick_i, .tick_o(tick16)
  );

  serial_tx #(.DW(DW), .OVS(OVS)) u_tx (
    .clk_i, .rst_ni, .tick_i(tick16), .start_i(wr_data && !is_shift),
    .nine_i(nine), .data_i(bus_wdata_i), .tb8_i(ctrl_q.tb8),
    .txd_o(a_txd), .done_o(a_tx_done)
  );

  serial_rx #(.DW(DW), .OVS(OVS)) u_rx (
    .clk_i, .rst_ni, .tick_i(tick16), .rxd_i(rxd_s),
    .ren_i(ctrl_q.ren && !is_shift), .nine_i(nine),
    .data_o(a_rx_data), .bit9_o(a_bit9), .done_o(a_rx_done)
  );

  serial_sync #(.DW(DW), .DIV(SHIFT_DIV)) u_sync (
    .clk_i, .rst_ni, .tx_start_i(wr_data && is_shift), .tx_data_i(bus_wdata_i),
    .rx_req_i(m0_rx_req), .rxd_i(rxd_s), .clk_o(s_clk), .dat_o(s_dat),
    .oe_o(s_oe), .busy_o(s_busy), .tx_done_o(s_tx_done),
    .rx_done_o(s_rx_done), .rx_data_o(s_rx_data)
  );

  assign tx_done_any = a_tx_done | s_tx_done;
  assign rx_done_any = a_rx_done | s_rx_done;
  assign rx_data_any = s_rx_done ? s_rx_data : a_rx_data;
  assign load_ok     = rx_done_any && !ctrl_q.ri;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      rbuf_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= sp_ctrl_t'(bus_wdata_i);
      if (tx_done_any) ctrl_q.ti <= 1'b1;
      if (load_ok) begin
        ctrl_q.ri <= 1'b1;
        rbuf_q    <= rx_data_any;
        if (a_rx_done) ctrl_q.rb8 <= a_bit9;
      end
    end
  end

  assign bus_rdata_o = (bus_addr_i == ADDR_CTRL) ? ctrl_q : rbuf_q;
  assign txd_o       = is_shift ? s_clk : a_txd;
  assign rxd_o       = s_dat;
  assign rxd_oe_o    = s_oe;

  // R13
  ti_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ctrl_q.ti) |-> $past(wr_ctrl));

  // R13
  ri_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ctrl_q.ri) |-> $past(wr_ctrl));

  // R10
  rbuf_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done_any && ctrl_q.ri) |=> $stable(rbuf_q));

  // R12
  m0_rx_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(s_busy) && !s_oe) |-> $past(ctrl_q.ren && !ctrl_q.ri && is_shift));
endmodule

// File: tb/sim_mcu_serial_port.sv
module sim_mcu_serial_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr = 1'b0, we = 1'b0, btick = 1'b0, rxd = 1'b1;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic rxd_o, rxd_oe, txd;
  int checks = 0, errors = 0;
  int bt_cnt = 0;

  always #4 clk = ~clk;

  mcu_serial_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_we_i(we),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .baud_tick_i(btick),
    .rxd_i(rxd), .rxd_o(rxd_o), .rxd_oe_o(rxd_oe), .txd_o(txd)
  );

  // 16x tick for mode 1: one pulse every 4 clocks -> 64-clock bits
  always @(negedge clk) begin
    bt_cnt = (bt_cnt + 1) % 4;
    btick  = (bt_cnt == 0);
  end

  // {mode[1:0], smod, tb8, data[7:0]}
  localparam logic [11:0] TXV [0:5] = '{12'h4A5, 12'h400, 12'h4FF,
                                        12'h93C, 12'hA81, 12'hB7E};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rdata;
  endtask

  function automatic logic [7:0] mk_ctrl(input logic smod, input logic tb8,
                                         input logic ren, input logic [1:0] mode);
    return {smod, 1'b0, 1'b0, 1'b0, tb8, ren, mode};
  endfunction

  function automatic logic [10:0] frame(input logic [7:0] d, input logic nine,
                                        input logic b9, input logic stop);
    return {stop, (nine ? b9 : stop), d, 1'b0};
  endfunction

  task automatic wait_txd(input logic lvl);
    int n = 0;
    while (txd !== lvl && n < 5000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 5000) chk(1'b0, "txd timeout", txd, lvl);
  endtask

  task automatic cap_frame(input int n, input int p, output logic [10:0] got);
    got = '1;
    wait_txd(1'b0);
    repeat (p / 2) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      got[i] = txd;
      if (i < n - 1) repeat (p) @(negedge clk);
    end
  endtask

  task automatic send(input logic [10:0] f, input int n, input int p, input int gbit);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rxd = f[i];
      if (i == gbit) begin
        repeat (p / 2) @(negedge clk);
        rxd = 1'b0;
        repeat (4) @(negedge clk);
        rxd = f[i];
        repeat (p / 2 - 5) @(negedge clk);
      end else begin
        repeat (p - 1) @(negedge clk);
      end
    end
    rxd = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [10:0] got, exp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    rd(1'b1, v); chk(v == 8'h00, "R1 ctrl", v, 0);
    rd(1'b0, v); chk(v == 8'h00, "R1 data", v, 0);
    chk(txd === 1'b1 && rxd_oe === 1'b0, "R1 pins", {txd, rxd_oe}, 2);

    // R3 / R4 transmit table
    for (int k = 0; k < 6; k++) begin
      logic [1:0] m = TXV[k][11:10];
      logic sm = TXV[k][9];
      logic t8 = TXV[k][8];
      logic [7:0] d = TXV[k][7:0];
      int nb = (m == 2'd2) ? 11 : 10;
      int p = (m == 2'd2 && sm) ? 32 : 64;
      wr(1'b1, mk_ctrl(sm, t8, 1'b0, m));
      wr(1'b0, d);
      exp = frame(d, m == 2'd2, t8, 1'b1);
      cap_frame(nb, p, got);
      if (m == 2'd2) chk(got == exp, "R4 frame", got, exp);
      else chk(got[9:0] == exp[9:0], "R3 frame", got[9:0], exp[9:0]);
      rd(1'b1, v); chk(v[5] == 1'b0, "R3 ti at mid-stop", v[5], 0);
      repeat (p / 2 + p / 16 + 4) @(negedge clk);
      rd(1'b1, v); chk(v[5] == 1'b1, "R3 ti after stop", v[5], 1);
      rd(1'b0, v); chk(v == 8'h00, "R2 rx buffer separate", v, 0);
    end

    // R5 mode 1 receive
    wr(1'b1, mk_ctrl(1'b0, 1'b0, 1'b1, 2'd1));
    send(frame(8'h96, 1'b0, 1'b0, 1'b1), 10, 64, -1);
    repeat (20) @(negedge clk);
    rd(1'b1, v); chk(v[6] && v[4], "R5 ri/rb8", v, 8'h50);
    rd(1'b0, v); chk(v == 8'h96, "R5 data", v, 8'h96);

    // R10 overrun keeps first byte
    send(frame(8'h11, 1'b0, 1'b0, 1'b1), 10, 64, -1);
    repeat (20) @(negedge clk);
    rd(1'b0, v); chk(v == 8'h96, "R10 overrun keeps", v, 8'h96);
    wr(1'b1, mk_ctrl(1'b0, 1'b0, 1'b1, 2'd1));
    send(frame(8'h22, 1'b0, 1'b0, 1'b1), 10, 64, -1);
    repeat (20) @(negedge clk);
    fork
      send(frame(8'h4B, 1'b0, 1'b0, 1'b1), 10, 64, -1);
      begin
        repeat (256) @(negedge clk);
        rd(1'b0, v); chk(v == 8'h22, "R10 read mid-frame", v, 8'h22);
        wr(1'b1, mk_ctrl(1'b0, 1'b0, 1'b1, 2'd1));
      end
    join
    repeat (20) @(negedge clk);
    rd(1'b0, v); chk(v == 8'h4B, "R10 second byte", v, 8'h4B);

    // R6 mode 2 receive, stop ignored
    wr(1'b1, mk_ctrl(1'b0, 1'b0, 1'b1, 2'd2));
    send(frame(8'h5D, 1'b1, 1'b1, 1'b0), 11, 64, -1);
    repeat (128) @(negedge clk);
    rd(1'b1, v); chk(v[6] && v[4], "R6 rb8=1 ri", v, 8'h56);
    rd(1'b0, v); chk(v == 8'h5D, "R6 data bad stop", v, 8'h5D);
    wr(1'b1, mk_ctrl(1'b0, 1'b0, 1'b1, 2'd2));
    send(frame(8'hC3, 1'b1, 1'b0, 1'b1), 11, 64, -1);
    repeat (20) @(negedge clk);
    rd(1'b1, v); chk(v[6] && !v[4], "R6 rb8=0", v, 8'h46);
    rd(1'b0, v); chk(v == 8'hC3, "R6 data", v, 8'hC3);

    // R7 one-sample glitch on data bit 3
    wr(1'b1, mk_ctrl(1'b0, 1'b0, 1'b1, 2'd1));
    send(frame(8'hFF, 1'b0, 1'b0, 1'b1), 10, 64, 4);
    repeat (20) @(negedge clk);
    rd(1'b0, v); chk(v == 8'hFF, "R7 majority", v, 8'hFF);

    // R8 false start
    wr(1'b1, mk_ctrl(1'b0, 1'b0, 1'b1, 2'd1));
    @(negedge clk); rxd = 1'b0;
    repeat (8) @(negedge clk); rxd = 1'b1;
    repeat (200) @(negedge clk);
    rd(1'b1, v); chk(v[6] == 1'b0, "R8 ri", v[6], 0);
    rd(1'b0, v); chk(v == 8'hFF, "R8 data", v, 8'hFF);

    // R9 REN off
    wr(1'b1, mk_ctrl(1'b0, 1'b0, 1'b0, 2'd1));
    send(frame(8'h33, 1'b0, 1'b0, 1'b1), 10, 64, -1);
    repeat (20) @(negedge clk);
    rd(1'b1, v); chk(v[6] == 1'b0, "R9 ri", v[6], 0);
    rd(1'b0, v); chk(v == 8'hFF, "R9 data", v, 8'hFF);

    // R14 full duplex
    wr(1'b1, mk_ctrl(1'b0, 1'b0, 1'b1, 2'd1));
    wr(1'b0, 8'h6C);
    fork
      cap_frame(10, 64, got);
      send(frame(8'hA9, 1'b0, 1'b0, 1'b1), 10, 64, -1);
    join
    exp = frame(8'h6C, 1'b0, 1'b0, 1'b1);
    chk(got[9:0] == exp[9:0], "R14 tx", got[9:0], exp[9:0]);
    repeat (64) @(negedge clk);
    rd(1'b0, v); chk(v == 8'hA9, "R14 rx", v, 8'hA9);

    // R13 flags sticky until control write
    repeat (200) @(negedge clk);
    rd(1'b0, v);
    rd(1'b1, v); chk(v[5] && v[6], "R13 sticky", v, 8'h65);
    wr(1'b1, mk_ctrl(1'b0, 1'b0, 1'b0, 2'd1));
    rd(1'b1, v); chk(!v[5] && !v[6], "R13 cleared", v, 8'h01);

    // R11 mode 0 transmit
    wr(1'b1, mk_ctrl(1'b0, 1'b0, 1'b0, 2'd0));
    wr(1'b0, 8'hB2);
    wait_txd(1'b0);
    for (int i = 0; i < 8; i++) begin
      repeat (3) @(negedge clk);
      chk(rxd_o == ((8'hB2 >> i) & 1) && rxd_oe && !txd, "R11 bit/low", {rxd_oe, txd, rxd_o}, 4 | ((8'hB2 >> i) & 1));
      repeat (6) @(negedge clk);
      chk(txd == 1'b1, "R11 clk high", txd, 1);
      repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    rd(1'b1, v); chk(v[5] && !rxd_oe, "R11 ti", v[5], 1);

    // R12 mode 0 receive gated by RI
    wr(1'b1, 8'h44);
    begin
      bit moved = 1'b0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (txd !== 1'b1) moved = 1'b1;
      end
      chk(!moved, "R12 blocked while ri", moved, 0);
    end
    wr(1'b1, mk_ctrl(1'b0, 1'b0, 1'b1, 2'd0));
    for (int i = 0; i < 8; i++) begin
      wait_txd(1'b0);
      rxd = (8'h4E >> i) & 1;
      wait_txd(1'b1);
    end
    repeat (12) @(negedge clk);
    rxd = 1'b1;
    rd(1'b1, v); chk(v[6], "R12 ri", v[6], 1);
    rd(1'b0, v); chk(v == 8'h4E, "R12 data", v, 8'h4E);
    wr(1'b1, mk_ctrl(1'b0, 1'b0, 1'b0, 2'd0));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule